// File: doc/BRIEF.md
# Light-Load PWM/PFM Mode Controller

This block generates the high-side and low-side gate pulses for one buck-converter channel and decides when the channel leaves fixed-frequency operation for pulse-frequency operation at light load. In PWM mode it runs back-to-back switching cycles. Each cycle is `sw_period` clocks long, and its high-side on-time comes from `duty_cmd`, which the control loop supplies. A dead time from `dead_clks` separates the two gates on every transition.

At the last clock of each PWM cycle the block compares the digitized inductor current with a threshold. When enough consecutive cycles fall below that threshold, it enters PFM mode. In PFM mode it stops following the control loop and freezes the on-time of the last PWM cycle. It keeps both gates off between pulses. It fires a single switching cycle each time the window comparator reports that the output has fallen below the reference. The length of each idle gap (the dead zone) is measured in clocks and reported with a strobe. If the window comparator reports that the output has left the high/low window, the block returns to PWM operation at once.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: While reset is low on a clock edge, the next clock shows `gate_hs` and `gate_ls` low, `pfm_active` low, `dead_zone_len` 0, `dead_zone_strobe` low, and a cleared light-load count. The first PWM cycle starts on the first edge after reset is released.
- R2: A switching cycle starts at a clock edge and captures `sw_period` (P) and the on-time (T) at that edge. It lasts P clocks (one clock when P is 0). The cycle counter t runs from 0 to P-1, and `gate_hs` is high exactly while t < T. In PWM mode T is `duty_cmd`, and each cycle is followed directly by the next one.
- R3: The dead time D is `dead_clks` captured at cycle start, with 0 treated as 1. `gate_ls` is high exactly while t >= T+D and t+D < P. The two gates are never high together, and neither rises on the clock where the other falls.
- R4: At the last clock of each PWM cycle, `isense` is compared with `light_thresh`. A value strictly below the threshold adds one to the count; a value at or above it clears the count. When a below-threshold sample would make the count reach `light_count` (0 acts as 1), that cycle is not followed by another. Instead `pfm_active` goes high from the next clock, with both gates off.
- R5: In PFM mode `duty_cmd` has no effect. Every PFM pulse uses as its on-time the T of the last PWM cycle before entry, applied to the `sw_period` captured at the pulse start.
- R6: In PFM mode with no pulse running, a pulse starts on the edge where `vo_under_ref` is high. No pulse starts without it. `vo_under_ref` has no effect while a pulse is running.
- R7: After a PFM pulse's P clocks both gates stay off until the next trigger.
- R8: `dead_zone_len` is set to the number of idle clocks before the triggering edge, the triggering clock included (minimum 1). It saturates at all ones and is held between updates. `dead_zone_strobe` is high for the one clock in which a new value is shown.
- R9: If `vo_over_hi` or `vo_under_lo` is high at an edge in PFM mode, `pfm_active` is low from the next clock. If no pulse was running, a PWM cycle with T = `duty_cmd` starts at that edge. If a pulse was running, it completes and PWM cycles follow it.
- R10: The light-load count is held at 0 throughout PFM mode, so a new entry needs a full new run of below-threshold cycles after returning to PWM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_period | input | PER_W | Switching period in clocks |
| duty_cmd | input | PER_W | High-side on-time from the control loop, in clocks |
| dead_clks | input | DT_W | Gate dead time in clocks (0 acts as 1) |
| isense | input | CUR_W | Digitized inductor current sample |
| light_thresh | input | CUR_W | Light-load current threshold |
| light_count | input | LL_W | Consecutive low-current cycles needed to enter PFM |
| vo_over_hi | input | 1 | Output above the high window limit |
| vo_under_ref | input | 1 | Output below the reference (PFM trigger) |
| vo_under_lo | input | 1 | Output below the low window limit |
| gate_hs | output | 1 | High-side gate drive |
| gate_ls | output | 1 | Low-side gate drive |
| pfm_active | output | 1 | High while in pulse-frequency mode |
| dead_zone_len | output | DZ_W | Last measured dead-zone length in clocks |
| dead_zone_strobe | output | 1 | One-clock pulse when `dead_zone_len` updates |

## Verification
The bench targets the edges of mode changes. A light-load run is broken by one high sample; a design that kept counting would enter PFM early. After PFM entry the duty command is changed, and a design that still followed the loop would produce wrong pulse widths. A violation is raised both in the middle of a PFM pulse and while idle, and a design that cut the pulse short or delayed the restart would show gates out of step. A zero dead-time setting, back-to-back triggers (dead zone of one) and a gap longer than the dead-zone counter's range catch a missing minimum dead time, an off-by-one idle count and a counter that wraps instead of saturating.

// File: rtl/pfm_pkg.sv
// Package: shared types for the light-load mode controller.
// Assumes nothing beyond 2-state enum encoding.
package pfm_pkg;

    typedef enum logic {
        MODE_PWM = 1'b0,
        MODE_PFM = 1'b1
    } sw_mode_e;

endpackage

// File: rtl/pfm_gate_timer.sv
// Gate timer: runs one switching cycle per start request.
// Captures period, on-time and dead time at start. Drives the high-side gate
// for the first on-time clocks and the low-side gate between the two dead-time
// gaps. It stops after the last clock unless restarted on that edge.
// Assumes DT_W <= PER_W.
module pfm_gate_timer #(
    parameter int PER_W = 8,
    parameter int DT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] per_in,
    input  logic [PER_W-1:0] ton_in,
    input  logic [DT_W-1:0]  dt_in,
    output logic             running,
    output logic             cycle_end,
    output logic [PER_W-1:0] ton_cur,
    output logic             hs,
    output logic             ls
);
    localparam int EW = PER_W + 1;

    logic [PER_W-1:0] cnt_q, per_q, ton_q;
    logic [DT_W-1:0]  dt_q, dt_eff;
    logic             run_q;
    logic [EW-1:0]    cnt_x, per_x, ton_x, dt_x;

    // Widen operands so the sums below cannot wrap.
    always_comb begin
        cnt_x  = {1'b0, cnt_q};
        per_x  = {1'b0, per_q};
        ton_x  = {1'b0, ton_q};
        dt_x   = EW'(dt_q);
        dt_eff = (dt_in == '0) ? DT_W'(1) : dt_in;
    end

    // Cycle end flag and gate windows, decoded from the counter.
    always_comb begin
        cycle_end = run_q && ((cnt_x + EW'(1)) >= per_x);
        hs        = run_q && (cnt_x < ton_x);
        ls        = run_q && (cnt_x >= (ton_x + dt_x)) && ((cnt_x + dt_x) < per_x);
    end

    // Cycle counter with parameter capture on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            per_q <= '0;
            ton_q <= '0;
            dt_q  <= DT_W'(1);
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            per_q <= per_in;
            ton_q <= ton_in;
            dt_q  <= dt_eff;
        end else if (cycle_end) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    assign running = run_q;
    assign ton_cur = ton_q;

endmodule

// File: rtl/pfm_light_load.sv
// Light-load detector: counts consecutive low-current cycle-end samples and
// raises enter when the programmed run length is reached.
// Assumes sample is a one-clock strobe at each PWM cycle end.
module pfm_light_load #(
    parameter int CUR_W = 10,
    parameter int LL_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [CUR_W-1:0] cur,
    input  logic [CUR_W-1:0] thresh,
    input  logic [LL_W-1:0]  need,
    output logic             enter
);
    localparam int EW = LL_W + 1;

    logic [LL_W-1:0] cnt_q;
    logic [EW-1:0]   need_x;
    logic            below;

    // Entry decision for the current sample.
    always_comb begin
        need_x = (need == '0) ? EW'(1) : {1'b0, need};
        below  = cur < thresh;
        enter  = sample && below && (({1'b0, cnt_q} + EW'(1)) >= need_x);
    end

    // Consecutive low-current cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || enter) begin
            cnt_q <= '0;
        end else if (sample) begin
            cnt_q <= below ? (cnt_q + LL_W'(1)) : '0;
        end
    end

endmodule

// File: rtl/pfm_mode_fsm.sv
// Mode sequencer: holds PWM/PFM mode and the on-time latched at PFM entry.
// Decides when the gate timer starts and which on-time it uses.
// Measures the dead zone between PFM pulses.
// Assumes running/cycle_end come from the gate timer.
module pfm_mode_fsm
    import pfm_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int DZ_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             cycle_end,
    input  logic             enter,
    input  logic             over_hi,
    input  logic             under_ref,
    input  logic             under_lo,
    input  logic [PER_W-1:0] duty_in,
    input  logic [PER_W-1:0] ton_cur,
    output logic             start,
    output logic [PER_W-1:0] ton_sel,
    output logic             sample_ll,
    output logic             clear_ll,
    output logic             pfm,
    output logic [DZ_W-1:0]  dz_len,
    output logic             dz_stb
);
    localparam logic [DZ_W-1:0] DZ_MAX = '1;

    sw_mode_e         mode_q;
    logic [PER_W-1:0] lat_q;
    logic [DZ_W-1:0]  dz_q, dz_len_q;
    logic             dz_stb_q, viol, trig;

    // Start request and on-time selection per mode.
    always_comb begin
        viol = over_hi || under_lo;
        trig = !running && !viol && under_ref;
        if (mode_q == MODE_PWM) begin
            sample_ll = cycle_end;
            start     = !running || (cycle_end && !enter);
            ton_sel   = duty_in;
        end else begin
            sample_ll = 1'b0;
            start     = (!running && (viol || under_ref)) || (cycle_end && viol);
            ton_sel   = viol ? duty_in : lat_q;
        end
        clear_ll = (mode_q == MODE_PFM);
    end

    // Mode transitions and duty latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PWM;
            lat_q  <= '0;
        end else if (mode_q == MODE_PWM) begin
            if (enter) begin
                mode_q <= MODE_PFM;
                lat_q  <= ton_cur;
            end
        end else if (viol) begin
            mode_q <= MODE_PWM;
        end
    end

    // Dead-zone counter and report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dz_q     <= '0;
            dz_len_q <= '0;
            dz_stb_q <= 1'b0;
        end else begin
            dz_stb_q <= 1'b0;
            if ((mode_q == MODE_PWM && enter) || (mode_q == MODE_PFM && cycle_end)) begin
                dz_q <= '0;
            end else if (mode_q == MODE_PFM && !running && !viol) begin
                if (trig) begin
                    dz_len_q <= (dz_q == DZ_MAX) ? DZ_MAX : (dz_q + DZ_W'(1));
                    dz_stb_q <= 1'b1;
                end else if (dz_q != DZ_MAX) begin
                    dz_q <= dz_q + DZ_W'(1);
                end
            end
        end
    end

    assign pfm    = (mode_q == MODE_PFM);
    assign dz_len = dz_len_q;
    assign dz_stb = dz_stb_q;

endmodule

// File: rtl/pfm_mode_ctrl.sv
// Top: one-channel PWM/PFM light-load controller. Connects the gate timer,
// the light-load detector and the mode sequencer.
// Assumes all inputs are synchronous to clk.
module pfm_mode_ctrl #(
    parameter int PER_W = 8,
    parameter int DT_W  = 3,
    parameter int CUR_W = 10,
    parameter int LL_W  = 6,
    parameter int DZ_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] sw_period,
    input  logic [PER_W-1:0] duty_cmd,
    input  logic [DT_W-1:0]  dead_clks,
    input  logic [CUR_W-1:0] isense,
    input  logic [CUR_W-1:0] light_thresh,
    input  logic [LL_W-1:0]  light_count,
    input  logic             vo_over_hi,
    input  logic             vo_under_ref,
    input  logic             vo_under_lo,
    output logic             gate_hs,
    output logic             gate_ls,
    output logic             pfm_active,
    output logic [DZ_W-1:0]  dead_zone_len,
    output logic             dead_zone_strobe
);
    logic             tmr_running, tmr_end, tmr_start, ll_enter, ll_sample, ll_clear;
    logic [PER_W-1:0] tmr_ton, ton_sel;

    pfm_gate_timer #(.PER_W(PER_W), .DT_W(DT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .per_in(sw_period), .ton_in(ton_sel), .dt_in(dead_clks),
        .running(tmr_running), .cycle_end(tmr_end), .ton_cur(tmr_ton),
        .hs(gate_hs), .ls(gate_ls)
    );

    pfm_light_load #(.CUR_W(CUR_W), .LL_W(LL_W)) u_light (
        .clk(clk), .rst_n(rst_n), .clear(ll_clear), .sample(ll_sample),
        .cur(isense), .thresh(light_thresh), .need(light_count), .enter(ll_enter)
    );

    pfm_mode_fsm #(.PER_W(PER_W), .DZ_W(DZ_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .running(tmr_running), .cycle_end(tmr_end),
        .enter(ll_enter), .over_hi(vo_over_hi), .under_ref(vo_under_ref),
        .under_lo(vo_under_lo), .duty_in(duty_cmd), .ton_cur(tmr_ton),
        .start(tmr_start), .ton_sel(ton_sel), .sample_ll(ll_sample),
        .clear_ll(ll_clear), .pfm(pfm_active), .dz_len(dead_zone_len),
        .dz_stb(dead_zone_strobe)
    );

endmodule

// File: rtl/pfm_mode_ctrl_chk.sv
// Checker: temporal properties of the controller, bound to the top module.
module pfm_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic gate_hs,
    input logic gate_ls,
    input logic pfm_active,
    input logic dead_zone_strobe,
    input logic vo_over_hi,
    input logic vo_under_ref,
    input logic vo_under_lo,
    input logic running
);
    // R1: a reset edge leaves gates off and PWM mode
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!gate_hs && !gate_ls && !pfm_active));

    assert_gates_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs && gate_ls));

    assert_hs_fall_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_hs) |-> !gate_ls);

    assert_ls_fall_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_ls) |-> !gate_hs);

    assert_entry_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfm_active) |-> !running);

    assert_no_spontaneous_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pfm_active && !running && !vo_under_ref && !vo_over_hi && !vo_under_lo) |=> !running);

    assert_strobe_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dead_zone_strobe |-> (running && pfm_active));

    assert_exit_on_violation_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pfm_active && (vo_over_hi || vo_under_lo)) |=> !pfm_active);

endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gate_hs(gate_hs), .gate_ls(gate_ls),
    .pfm_active(pfm_active), .dead_zone_strobe(dead_zone_strobe),
    .vo_over_hi(vo_over_hi), .vo_under_ref(vo_under_ref),
    .vo_under_lo(vo_under_lo), .running(tmr_running)
);

// File: tb/test_pfm_mode_ctrl.sv
module test_pfm_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DZ_MAX = 4095;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw_period = 8'd20, duty_cmd = 8'd7;
    logic [2:0] dead_clks = 3'd2;
    logic [9:0] isense = 10'd500, light_thresh = 10'd100;
    logic [5:0] light_count = 6'd3;
    logic       vo_over_hi = 1'b0, vo_under_ref = 1'b0, vo_under_lo = 1'b0;
    logic       gate_hs, gate_ls, pfm_active, dead_zone_strobe;
    logic [11:0] dead_zone_len;

    int checks = 0, failures = 0, cycles = 0;
    int exp_lat = 5;

    pfm_mode_ctrl i_pfm_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sw_period(sw_period), .duty_cmd(duty_cmd),
        .dead_clks(dead_clks), .isense(isense), .light_thresh(light_thresh),
        .light_count(light_count), .vo_over_hi(vo_over_hi), .vo_under_ref(vo_under_ref),
        .vo_under_lo(vo_under_lo), .gate_hs(gate_hs), .gate_ls(gate_ls),
        .pfm_active(pfm_active), .dead_zone_len(dead_zone_len),
        .dead_zone_strobe(dead_zone_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    int m_mode = 0, m_run = 0, m_cnt = 0, m_per = 0, m_ton = 0, m_dt = 1;
    int m_lat = 0, m_lite = 0, m_dz = 0, m_dzlen = 0, m_dzv = 0;
    bit started = 0;

    task automatic m_start(input int ton);
        m_cnt = 0; m_per = sw_period; m_ton = ton;
        m_dt = (dead_clks == 0) ? 1 : dead_clks; m_run = 1;
    endtask

    always @(posedge clk) begin
        int nn;
        bit endc, viol;
        cycles++;
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_run = 0; m_cnt = 0; m_per = 0; m_ton = 0; m_dt = 1;
            m_lat = 0; m_lite = 0; m_dz = 0; m_dzlen = 0; m_dzv = 0;
        end else begin
            endc = m_run && (m_cnt + 1 >= m_per);
            nn = (light_count == 0) ? 1 : light_count;
            viol = vo_over_hi || vo_under_lo;
            m_dzv = 0;
            if (m_mode == 0) begin
                if (!m_run) m_start(duty_cmd);
                else if (endc) begin
                    if (isense < light_thresh && m_lite + 1 >= nn) begin
                        m_mode = 1; m_lat = m_ton; m_lite = 0; m_run = 0; m_dz = 0;
                    end else begin
                        m_lite = (isense < light_thresh) ? m_lite + 1 : 0;
                        m_start(duty_cmd);
                    end
                end else m_cnt++;
            end else if (m_run) begin
                if (endc) begin
                    if (viol) begin m_mode = 0; m_start(duty_cmd); end
                    else begin m_run = 0; m_dz = 0; end
                end else begin
                    m_cnt++;
                    if (viol) m_mode = 0;
                end
            end else begin
                if (viol) begin m_mode = 0; m_start(duty_cmd); end
                else if (vo_under_ref) begin
                    m_dzlen = (m_dz + 1 > DZ_MAX) ? DZ_MAX : m_dz + 1;
                    m_dzv = 1;
                    m_start(m_lat);
                end else if (m_dz < DZ_MAX) m_dz++;
            end
        end
    end

    // Per-clock comparison with the reference, away from the active edge
    int hs_run = 0;
    logic hs_prev = 1'b0;
    always @(negedge clk) begin
        bit e_hs, e_ls;
        if (started) begin
            e_hs = m_run && (m_cnt < m_ton);
            e_ls = m_run && (m_cnt >= m_ton + m_dt) && (m_cnt + m_dt < m_per);
            checks++;
            if (gate_hs !== e_hs || gate_ls !== e_ls) begin
                failures++;
                $display("FAIL R2 R3 R5 R7 gates hs=%0b ls=%0b expected hs=%0b ls=%0b at cycle %0d",
                         gate_hs, gate_ls, e_hs, e_ls, cycles);
            end
            checks++;
            if (pfm_active !== m_mode[0]) begin
                failures++;
                $display("FAIL R4 R9 R10 pfm_active=%0b expected %0b at cycle %0d",
                         pfm_active, m_mode[0], cycles);
            end
            checks++;
            if (dead_zone_len !== 12'(m_dzlen) || dead_zone_strobe !== m_dzv[0]) begin
                failures++;
                $display("FAIL R6 R8 dz len=%0d stb=%0b expected len=%0d stb=%0b at cycle %0d",
                         dead_zone_len, dead_zone_strobe, m_dzlen, m_dzv, cycles);
            end
            checks++;
            if (gate_hs && gate_ls) begin
                failures++;
                $display("FAIL R3 overlap hs=1 ls=1 expected never both");
            end
            // R5: width of every PFM high-side pulse equals the latched duty
            if (hs_prev && !gate_hs && pfm_active) begin
                checks++;
                if (hs_run != exp_lat) begin
                    failures++;
                    $display("FAIL R5 pfm pulse width=%0d expected %0d", hs_run, exp_lat);
                end
            end
            hs_run  = gate_hs ? hs_run + 1 : 0;
            hs_prev = gate_hs;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_mode(input bit want, input string tag);
        int k = 0;
        while (pfm_active !== want && k < 2000) begin step(1); k++; end
        checks++;
        if (pfm_active !== want) begin
            failures++;
            $display("FAIL %s pfm_active=%0b expected %0b", tag, pfm_active, want);
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset state at the ports
        checks++;
        if (gate_hs || gate_ls || pfm_active || dead_zone_len != 0 || dead_zone_strobe) begin
            failures++;
            $display("FAIL R1 reset outputs hs=%0b ls=%0b pfm=%0b len=%0d expected all 0",
                     gate_hs, gate_ls, pfm_active, dead_zone_len);
        end
        rst_n = 1'b1;
        step(60);                                      // R2 plain PWM
        duty_cmd = 8'd12; dead_clks = 3'd0; step(40);  // R3 zero dead time acts as 1
        duty_cmd = 8'd5;  dead_clks = 3'd3; step(45);
        isense = 10'd50;  step(40);                    // R4 two low cycles
        isense = 10'd100; step(20);                    // at threshold clears count
        checks++;
        if (pfm_active) begin
            failures++;
            $display("FAIL R4 entered early pfm_active=1 expected 0");
        end
        isense = 10'd50;
        wait_mode(1'b1, "R4 entry");
        exp_lat = 5;
        duty_cmd = 8'd15;                               // R5 ignored in PFM
        step(10); vo_under_ref = 1'b1; step(1); vo_under_ref = 1'b0;   // R6 R8
        step(40);
        vo_under_ref = 1'b1; step(60); vo_under_ref = 1'b0;           // back-to-back, dz=1
        step(30); vo_under_ref = 1'b1; step(1); vo_under_ref = 1'b0;
        step(8); vo_over_hi = 1'b1; duty_cmd = 8'd9; step(1); vo_over_hi = 1'b0;  // R9 mid pulse
        checks++;
        if (pfm_active) begin
            failures++;
            $display("FAIL R9 pfm_active=1 expected 0 after over-high");
        end
        step(2);
        exp_lat = 9;
        wait_mode(1'b1, "R10 re-entry");
        step(15); vo_under_lo = 1'b1; step(1); vo_under_lo = 1'b0;     // R9 from idle
        isense = 10'd500; step(50);
        light_count = 6'd0; isense = 10'd50;
        wait_mode(1'b1, "R4 count zero");
        step(4200); vo_under_ref = 1'b1; step(1); vo_under_ref = 1'b0; // R8 saturation
        checks++;
        if (dead_zone_len != 12'(DZ_MAX)) begin
            failures++;
            $display("FAIL R8 saturated len=%0d expected %0d", dead_zone_len, DZ_MAX);
        end
        step(30); vo_over_hi = 1'b1; step(1); vo_over_hi = 1'b0;
        step(50);
        finish_run();
    end
endmodule